// File: doc/BRIEF.md
# Frame Sync Hunt State Machine

This block follows receive frame delineation from one strobe per codeword. At each codeword boundary an upstream detector pulses `hit_i` when the expected sync pattern was found, or `miss_i` when it was not. The block does not search for the pattern itself. It keeps a four-state machine: hunting, two freewheel states and locked. In the two freewheel states it counts consecutive misses. Each freewheel state compares its count against its own programmable threshold, so a locked receiver loses sync in two stages rather than in one step.

Software loads the two 16-bit thresholds through a small write port. One select bit picks which threshold is written. The current state comes out as a 2-bit code together with a synced flag. A one-bit status from the far-end receiver is registered and passed through unchanged.

Top module: `frame_sync_hunt`

## Requirements
- R1: During reset and after it, `state_o` is 0 (Looking), `synced_o` is 0 and `remote_sync_o` is 0. The drop threshold resets to 3 and the demote threshold resets to 7.
- R2: `state_o` uses this encoding: 0 Looking, 1 Freewheel-Sync-False, 2 Synced, 3 Freewheel-Sync-True. `synced_o` is 1 exactly when the code is 2 or 3.
- R3: In Looking, a hit moves the machine to Freewheel-Sync-False. A miss leaves it in Looking.
- R4: In Freewheel-Sync-False, a hit moves the machine to Synced. When the run of consecutive misses reaches the drop threshold, the machine moves to Looking.
- R5: In Synced, a single miss moves the machine to Freewheel-Sync-True. A hit keeps it in Synced.
- R6: In Freewheel-Sync-True, a hit returns the machine to Synced. When the run of consecutive misses reaches the demote threshold, the machine moves to Freewheel-Sync-False.
- R7: A hit clears the miss run, and every state change clears it. The miss run saturates at its maximum and never wraps to zero.
- R8: A cycle with `cfg_wr_i` high loads `cfg_data_i` into the drop threshold when `cfg_sel_i` is 0, and into the demote threshold when `cfg_sel_i` is 1. The new value applies to strobes in later cycles. A threshold of 0 acts like 1.
- R9: When `hit_i` and `miss_i` are both high in one cycle, the cycle counts as a hit.
- R10: `remote_sync_o` equals `remote_sync_i` one cycle later (0 = far end out of sync, 1 = synced).
- R11: A strobe sampled at one clock edge shows its effect on `state_o` and `synced_o` straight after that edge. A cycle with no strobe changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| hit_i | input | 1 | Sync pattern seen at this codeword boundary |
| miss_i | input | 1 | Sync pattern missed at this codeword boundary |
| cfg_wr_i | input | 1 | Threshold write strobe |
| cfg_sel_i | input | 1 | 0 selects the drop threshold, 1 selects the demote threshold |
| cfg_data_i | input | 16 | Threshold value to write |
| remote_sync_i | input | 1 | Far-end receiver status |
| state_o | output | 2 | Current delineation state code |
| synced_o | output | 1 | High in Synced and Freewheel-Sync-True |
| remote_sync_o | output | 1 | Registered far-end status |

## Verification
Every result of this block is due one clock edge after the cycle that causes it: the state and synced flag after a strobe, the far-end status after a change on its input, and a threshold written in one cycle applies from the next strobe onward. The bench drives each stimulus on a falling edge and samples one time unit after the following rising edge. Its reference model advances exactly once per such edge, so every comparison lines up with the single register stage. Threshold writes advance the model's threshold copies at the same edge.

// File: rtl/frame_sync_hunt.sv
module frame_sync_hunt #(
  parameter int CNT_W        = 16,
  parameter int DROP_TH_RST  = 3,
  parameter int DEMOTE_TH_RST = 7
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             hit_i,
  input  logic             miss_i,
  input  logic             cfg_wr_i,
  input  logic             cfg_sel_i,
  input  logic [CNT_W-1:0] cfg_data_i,
  input  logic             remote_sync_i,
  output logic [1:0]       state_o,
  output logic             synced_o,
  output logic             remote_sync_o
);

  localparam logic [1:0] ST_LOOK = 2'd0;
  localparam logic [1:0] ST_FWF  = 2'd1;
  localparam logic [1:0] ST_SYNC = 2'd2;
  localparam logic [1:0] ST_FWT  = 2'd3;

  logic [1:0]       st_q, st_d;
  logic [CNT_W-1:0] run_q, run_d;
  logic [CNT_W-1:0] drop_th_q, demote_th_q;
  logic             remote_q;

  wire             lone_miss = miss_i & ~hit_i;
  wire [CNT_W:0]   run_inc   = {1'b0, run_q} + 1'b1;
  wire [CNT_W-1:0] run_sat   = run_inc[CNT_W] ? {CNT_W{1'b1}} : run_inc[CNT_W-1:0];
  wire             drop_hit  = run_inc >= {1'b0, drop_th_q};
  wire             demote_hit = run_inc >= {1'b0, demote_th_q};

  always_comb begin
    st_d  = st_q;
    run_d = run_q;
    case (st_q)
      ST_LOOK: if (hit_i) st_d = ST_FWF;
      ST_SYNC: if (lone_miss) st_d = ST_FWT;
      ST_FWF: begin
        if (hit_i) st_d = ST_SYNC;
        else if (lone_miss) begin
          if (drop_hit) st_d = ST_LOOK;
          else run_d = run_sat;
        end
      end
      default: begin
        if (hit_i) st_d = ST_SYNC;
        else if (lone_miss) begin
          if (demote_hit) st_d = ST_FWF;
          else run_d = run_sat;
        end
      end
    endcase
    if (hit_i || st_d != st_q) run_d = '0;
  end

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      st_q        <= ST_LOOK;
      run_q       <= '0;
      drop_th_q   <= CNT_W'(DROP_TH_RST);
      demote_th_q <= CNT_W'(DEMOTE_TH_RST);
      remote_q    <= 1'b0;
    end else begin
      st_q     <= st_d;
      run_q    <= run_d;
      remote_q <= remote_sync_i;
      if (cfg_wr_i && !cfg_sel_i) drop_th_q   <= cfg_data_i;
      if (cfg_wr_i &&  cfg_sel_i) demote_th_q <= cfg_data_i;
    end
  end

  assign state_o       = st_q;
  assign synced_o      = st_q[1];
  assign remote_sync_o = remote_q;

  assert_look_hit_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_LOOK && hit_i) |=> state_o == ST_FWF);
  assert_look_miss_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_LOOK && !hit_i) |=> state_o == ST_LOOK);
  assert_sync_miss_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_SYNC && miss_i && !hit_i) |=> state_o == ST_FWT);
  assert_fw_hit_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q[0] && hit_i) |=> state_o == ST_SYNC);
  assert_hit_wins_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit_i && miss_i && st_q != ST_LOOK) |=> state_o == ST_SYNC);
  assert_run_no_wrap_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_q != '0 && !hit_i && !$changed(st_q)) |=> (run_q >= $past(run_q) || st_q != $past(st_q)));
  assert_idle_hold_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!hit_i && !miss_i) |=> $stable(state_o));
  assert_remote_pass_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> remote_sync_o == $past(remote_sync_i));
  assert_jump_legal_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_LOOK) |=> state_o != ST_SYNC && state_o != ST_FWT);

endmodule

// File: tb/test_frame_sync_hunt.sv
module test_frame_sync_hunt;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        hit = 1'b0, miss = 1'b0, cfg_wr = 1'b0, cfg_sel = 1'b0, rem = 1'b0;
  logic [15:0] cfg_data = '0;
  logic [1:0]  state;
  logic        synced, rem_o;

  int n_chk = 0, n_fail = 0;
  int m_st = 0, m_run = 0, m_drop = 3, m_dem = 7;
  bit done = 0;

  frame_sync_hunt i_frame_sync_hunt (
    .clk_i(clk), .rst_ni(rst_n), .hit_i(hit), .miss_i(miss),
    .cfg_wr_i(cfg_wr), .cfg_sel_i(cfg_sel), .cfg_data_i(cfg_data),
    .remote_sync_i(rem), .state_o(state), .synced_o(synced), .remote_sync_o(rem_o));

  always #5 clk = ~clk;

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic string rule_of(input int st, input logic h, input logic m);
    if (h && m) return "R9";
    case (st)
      0: return "R3";
      1: return "R4";
      2: return "R5";
      default: return "R6";
    endcase
  endfunction

  task automatic model(input logic h, input logic m);
    int nst = m_st;
    int th;
    if (h) begin
      if (m_st == 0) nst = 1; else nst = 2;
      m_run = 0;
    end else if (m) begin
      if (m_st == 2) nst = 3;
      else if (m_st == 1 || m_st == 3) begin
        th = (m_st == 1) ? m_drop : m_dem;
        if (m_run + 1 >= th) nst = (m_st == 1) ? 0 : 1;
        else m_run = (m_run + 1 > 65535) ? 65535 : m_run + 1;
      end
    end
    if (nst != m_st) m_run = 0;
    m_st = nst;
  endtask

  task automatic step(input logic h, input logic m, input logic r, input string tag);
    string t;
    @(negedge clk);
    hit = h; miss = m; rem = r;
    t = (tag == "") ? rule_of(m_st, h, m) : tag;
    @(posedge clk); #1;
    model(h, m);
    chk({t, " R11 state"}, int'(state), m_st);
    chk("R2 synced", int'(synced), (m_st >= 2) ? 1 : 0);
    chk("R10 remote", int'(rem_o), int'(r));
    hit = 1'b0; miss = 1'b0;
  endtask

  task automatic wcfg(input logic sel, input int val);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_sel = sel; cfg_data = 16'(val);
    @(posedge clk); #1;
    cfg_wr = 1'b0;
    if (sel) m_dem = val; else m_drop = val;
  endtask

  task automatic to_sync();
    step(1, 0, rem, "");
    if (m_st != 2) step(1, 0, rem, "");
    if (m_st != 2) step(1, 0, rem, "");
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk); #1;
    chk("R1 state in reset", int'(state), 0);
    chk("R1 synced in reset", int'(synced), 0);
    chk("R1 remote in reset", int'(rem_o), 0);
    @(negedge clk); rst_n = 1'b1;
    @(posedge clk); #1;
    chk("R1 state after reset", int'(state), 0);

    step(0, 1, 0, "R3");
    step(0, 0, 1, "R11");
    step(1, 0, 1, "R3");
    step(0, 1, 1, "R1");
    step(0, 1, 0, "R1");
    step(0, 1, 0, "R1");
    chk("R1 default drop threshold", int'(state), 0);

    to_sync();
    step(0, 1, 0, "R5");
    for (int i = 0; i < 5; i++) step(0, 1, 0, "R6");
    step(1, 0, 0, "R7");
    step(0, 1, 0, "R5");
    for (int i = 0; i < 6; i++) step(0, 1, 0, "R7");
    chk("R7 run restart", int'(state), 3);
    step(0, 1, 0, "R1");
    chk("R1 default demote threshold", int'(state), 1);
    step(0, 1, 0, "R7");
    chk("R7 run cleared on demote", int'(state), 1);
    step(1, 1, 0, "R9");
    chk("R9 hit wins", int'(state), 2);

    wcfg(1'b1, 2);
    wcfg(1'b0, 0);
    step(0, 1, 0, "R8");
    step(0, 1, 0, "R8");
    step(0, 1, 0, "R8");
    chk("R8 demote threshold 2", int'(state), 1);
    step(0, 1, 0, "R8");
    chk("R8 zero threshold acts as one", int'(state), 0);
    step(1, 1, 0, "R9");

    for (int i = 0; i < 4000; i++) begin
      int sel = $urandom_range(0, 99);
      if (sel < 3) wcfg(1'($urandom_range(0, 1)), $urandom_range(0, 9));
      else if (sel < 50) step(0, 1, 1'($urandom_range(0, 1)), "");
      else if (sel < 75) step(1, 0, 1'($urandom_range(0, 1)), "");
      else if (sel < 82) step(1, 1, 1'($urandom_range(0, 1)), "");
      else step(0, 0, 1'($urandom_range(0, 1)), "R11");
    end

    wcfg(1'b1, 65535);
    to_sync();
    step(0, 1, 0, "R5");
    for (int i = 0; i < 200; i++) step(0, 1, 0, "R7");
    chk("R7 large threshold holds", int'(state), 3);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin : seed
    int s;
    s = $urandom(32'd1234);
  end
endmodule